// File: doc/BRIEF.md
# Parallel EEPROM Sequential Dump Controller

This controller reads a byte-wide parallel EEPROM from address zero upward and hands every byte it reads to a downstream consumer over a valid/ready stream. The memory's address lines are not driven directly. They come from an external serial-in, parallel-out shift register chain. The controller feeds that chain through two pins: a serial data pin and a shift clock pin.

A dump begins with a one-cycle `start` pulse, which also latches the requested byte count. Each byte is fetched in three steps. First the current address is clocked into the external chain. Then a timed read strobe sequence runs on the active-low chip-enable and output-enable pins. Finally the sampled byte is held on the output until the consumer accepts it. The write-enable pin never leaves its inactive level.

When the requested number of bytes has been accepted, the controller returns to idle and raises `done`. `done` stays high until the next dump is started. The output-enable wait is derived from the system clock frequency and the memory's access time. Both are parameters.

Top module: `eeprom_dump`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `ce_n`, `oe_n` and `we_n` are 1, `sr_clk` is 0, and `out_valid`, `busy` and `done` are 0.
- R2: For each address, exactly 16 rising edges of `sr_clk` occur before the read strobe. The 16-bit address goes out most significant bit first, which means the high byte comes before the low byte. `sr_data` is set at least one clock cycle before the rising edge that captures it. `sr_clk` is low whenever `ce_n` is low.
- R3: The addresses presented to the shift chain during one dump are 0, 1, 2 and so on, in order. The low address byte increments after each shift, and its wrap from 0xFF to 0x00 carries into the high byte (0x00FF is followed by 0x0100).
- R4: A read drives `ce_n` low, then `oe_n` low one cycle later. Afterwards `oe_n` returns high one cycle before `ce_n` does. `oe_n` is never low while `ce_n` is high.
- R5: `oe_n` is held low for ACC = ceil(ACCESS_NS × CLK_MHZ / 1000) clock cycles before `mem_data` is sampled. With the default values this is 9 cycles.
- R6: `we_n` stays 1 at all times.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` is stable. No rising edge of `sr_clk` occurs while `out_valid` is 1.
- R8: The bytes accepted during a dump are the memory contents at addresses 0, 1, 2 and so on, in order. The first byte is the content of address 0, and exactly `dump_len` bytes are delivered.
- R9: After the last byte is accepted, `done` rises and `busy` falls. `done` stays high with `out_valid` low until the next `start`.
- R10: A `start` with `dump_len` equal to 0 raises `done` on the next cycle. No byte is delivered and `ce_n` does not fall.
- R11: A `start` pulse while `busy` is 1 is ignored. The dump in progress keeps its original length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a dump from address 0 |
| dump_len | input | LEN_W (17) | Number of bytes to read, latched on `start` |
| sr_data | output | 1 | Serial data into the external address shift register |
| sr_clk | output | 1 | Shift clock of the external address shift register |
| ce_n | output | 1 | Memory chip enable, active low |
| oe_n | output | 1 | Memory output enable, active low |
| we_n | output | 1 | Memory write enable, active low, held inactive |
| mem_data | input | DATA_W (8) | Memory data bus |
| out_data | output | DATA_W (8) | Byte read from memory |
| out_valid | output | 1 | `out_data` holds a byte not yet accepted |
| out_ready | input | 1 | Consumer accepts the byte when high with `out_valid` |
| busy | output | 1 | A dump is in progress |
| done | output | 1 | The last dump finished; held until the next `start` |

## Verification
The bench uses a memory model that returns a distinct byte per address. It returns that byte only when both strobes are low and output-enable has been low long enough, and a filler value otherwise. So a short access wait, a shifted-out address one off, or a missing leading byte all show up as wrong data. Dumps run with a consumer that is always ready, with one that stalls every third cycle, and with one that stalls for long runs. Comparing these separates correct handshake holding from dropped or repeated bytes. A 260-byte dump crosses the low-byte wrap and checks the carry into the high byte. A zero-length dump, and a `start` pulse issued in the middle of a dump, check the edge cases of the length control.

// File: rtl/eeprom_dump_pkg.sv
package eeprom_dump_pkg;

  typedef enum logic [2:0] {
    C_IDLE,
    C_SHGO,
    C_SHWAIT,
    C_RDGO,
    C_RDWAIT,
    C_HOLD
  } ctrl_st_t;

  typedef enum logic [1:0] {
    R_IDLE,
    R_CE,
    R_WAIT,
    R_OFF
  } rd_st_t;

  // Access wait in clock cycles, rounded up, never below one.
  function automatic int unsigned access_cycles(input int unsigned ns,
                                                input int unsigned mhz);
    int unsigned c;
    c = (ns * mhz + 999) / 1000;
    if (c == 0) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/eeprom_dump_shift.sv
// Serializes one address word into an external shift register, MSB first.
// Each bit takes two cycles: data placed with the clock low, then clock high.
module eeprom_dump_shift #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] word,
  output logic              sr_data,
  output logic              sr_clk,
  output logic              fin
);

  localparam int IDX_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;

  logic              active;
  logic              phase;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      phase   <= 1'b0;
      idx     <= '0;
      pend    <= '0;
      sr_data <= 1'b0;
      sr_clk  <= 1'b0;
      fin     <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (!active) begin
        if (go) begin
          active  <= 1'b1;
          phase   <= 1'b0;
          idx     <= '0;
          pend    <= word << 1;
          sr_data <= word[ADDR_W-1];
          sr_clk  <= 1'b0;
        end
      end else if (!phase) begin
        sr_clk <= 1'b1;
        phase  <= 1'b1;
      end else begin
        sr_clk <= 1'b0;
        phase  <= 1'b0;
        if (idx == IDX_W'(ADDR_W - 1)) begin
          active <= 1'b0;
          fin    <= 1'b1;
        end else begin
          idx     <= idx + 1'b1;
          sr_data <= pend[ADDR_W-1];
          pend    <= pend << 1;
        end
      end
    end
  end

endmodule

// File: rtl/eeprom_dump_strobe.sv
// One timed read: CE low, OE low, wait, sample, OE high, CE high.
module eeprom_dump_strobe
  import eeprom_dump_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ACC_CYC = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [DATA_W-1:0] mem_data,
  output logic              ce_n,
  output logic              oe_n,
  output logic [DATA_W-1:0] rd_byte,
  output logic              fin
);

  localparam int CNT_W = $clog2(ACC_CYC + 1);

  rd_st_t           st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= R_IDLE;
      cnt     <= '0;
      ce_n    <= 1'b1;
      oe_n    <= 1'b1;
      rd_byte <= '0;
      fin     <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (st)
        R_IDLE: begin
          if (go) begin
            ce_n <= 1'b0;
            st   <= R_CE;
          end
        end
        R_CE: begin
          oe_n <= 1'b0;
          cnt  <= '0;
          st   <= R_WAIT;
        end
        R_WAIT: begin
          if (cnt == CNT_W'(ACC_CYC - 1)) begin
            rd_byte <= mem_data;
            oe_n    <= 1'b1;
            st      <= R_OFF;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        R_OFF: begin
          ce_n <= 1'b1;
          fin  <= 1'b1;
          st   <= R_IDLE;
        end
        default: st <= R_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eeprom_dump.sv
module eeprom_dump
  import eeprom_dump_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int LEN_W     = ADDR_W + 1,
  parameter int CLK_MHZ   = 125,
  parameter int ACCESS_NS = 70
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  dump_len,
  output logic              sr_data,
  output logic              sr_clk,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n,
  input  logic [DATA_W-1:0] mem_data,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              busy,
  output logic              done
);

  localparam int ACC_CYC = int'(access_cycles(ACCESS_NS, CLK_MHZ));
  localparam int LO_W    = ADDR_W / 2;
  localparam int HI_W    = ADDR_W - LO_W;

  ctrl_st_t          st;
  logic [LO_W-1:0]   addr_lo;
  logic [HI_W-1:0]   addr_hi;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  cnt;
  logic              sh_go, sh_fin;
  logic              rd_go, rd_fin;
  logic [DATA_W-1:0] rd_byte;

  assign sh_go = (st == C_SHGO);
  assign rd_go = (st == C_RDGO);

  eeprom_dump_shift #(.ADDR_W(ADDR_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .go      (sh_go),
    .word    ({addr_hi, addr_lo}),
    .sr_data (sr_data),
    .sr_clk  (sr_clk),
    .fin     (sh_fin)
  );

  eeprom_dump_strobe #(.DATA_W(DATA_W), .ACC_CYC(ACC_CYC)) u_strobe (
    .clk      (clk),
    .rst      (rst),
    .go       (rd_go),
    .mem_data (mem_data),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .rd_byte  (rd_byte),
    .fin      (rd_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= C_IDLE;
      addr_lo   <= '0;
      addr_hi   <= '0;
      len_q     <= '0;
      cnt       <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      we_n      <= 1'b1;
    end else begin
      we_n <= 1'b1;
      case (st)
        C_IDLE: begin
          if (start) begin
            len_q   <= dump_len;
            addr_lo <= '0;
            addr_hi <= '0;
            cnt     <= '0;
            if (dump_len == '0) begin
              done <= 1'b1;
            end else begin
              done <= 1'b0;
              busy <= 1'b1;
              st   <= C_SHGO;
            end
          end
        end
        C_SHGO: st <= C_SHWAIT;
        C_SHWAIT: begin
          if (sh_fin) begin
            addr_lo <= addr_lo + 1'b1;
            if (addr_lo == {LO_W{1'b1}}) addr_hi <= addr_hi + 1'b1;
            st <= C_RDGO;
          end
        end
        C_RDGO: st <= C_RDWAIT;
        C_RDWAIT: begin
          if (rd_fin) begin
            out_data  <= rd_byte;
            out_valid <= 1'b1;
            st        <= C_HOLD;
          end
        end
        C_HOLD: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            cnt       <= cnt + 1'b1;
            if (cnt + 1'b1 == len_q) begin
              done <= 1'b1;
              busy <= 1'b0;
              st   <= C_IDLE;
            end else begin
              st <= C_SHGO;
            end
          end
        end
        default: st <= C_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eeprom_dump_chk.sv
module eeprom_dump_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              sr_clk,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              busy,
  input logic              done
);

  AST_WE_STAYS_HIGH: assert property (@(posedge clk) disable iff (rst) we_n); // R6
  AST_OE_INSIDE_CE: assert property (@(posedge clk) disable iff (rst) !oe_n |-> !ce_n); // R4
  AST_CE_LEADS_OE: assert property (@(posedge clk) disable iff (rst) $fell(oe_n) |-> $past(!ce_n)); // R4
  AST_OE_RISES_FIRST: assert property (@(posedge clk) disable iff (rst) $rose(ce_n) |-> (oe_n && $past(oe_n))); // R4
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst) (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7
  AST_NO_SHIFT_WHILE_HELD: assert property (@(posedge clk) disable iff (rst) out_valid |-> !sr_clk); // R7
  AST_QUIET_SHIFT_IN_READ: assert property (@(posedge clk) disable iff (rst) !ce_n |-> !sr_clk); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> (!busy && !out_valid)); // R9

endmodule

bind eeprom_dump eeprom_dump_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/eeprom_dump_test.sv
module eeprom_dump_test;

  localparam int ACC = (70 * 125 + 999) / 1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [16:0] dump_len = '0;
  logic        sr_data, sr_clk, ce_n, oe_n, we_n;
  logic [7:0]  mem_data;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        busy, done;

  always #4 clk = ~clk;

  eeprom_dump uut (
    .clk(clk), .rst(rst), .start(start), .dump_len(dump_len),
    .sr_data(sr_data), .sr_clk(sr_clk), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .mem_data(mem_data), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .busy(busy), .done(done)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [7:0] expq[$];
  int ready_mode = 0;
  int rcv = 0;
  int reads = 0;
  int pulses = 0;
  int last_pulses = 0;
  int oe_low = 0;
  logic [15:0] exp_addr = '0;
  logic [15:0] sr_model = '0;
  int oe_cyc = 0;
  logic pv = 1'b0, pr = 1'b0, pce = 1'b1, poe = 1'b1;
  logic [7:0] pd = '0;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return (a[7:0] + (a[15:8] * 8'd7)) ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // External shift register and memory model
  always @(posedge sr_clk) begin
    sr_model <= {sr_model[14:0], sr_data};
    pulses++;
    if (!rst) chk(!out_valid, "R7", "shift clock rose while byte held", 1, 0);
  end

  always @(posedge clk) oe_cyc <= oe_n ? 0 : oe_cyc + 1;

  assign mem_data = (!ce_n && !oe_n && oe_cyc >= ACC - 1) ? memf(sr_model) : 8'hEE;

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      case (ready_mode)
        0: out_ready = 1'b1;
        1: out_ready = (cyc % 3) != 0;
        default: out_ready = (cyc % 17) >= 12;
      endcase
      if (pv && !pr)
        chk(out_valid && out_data == pd, "R7", "held byte changed", int'(out_data), int'(pd));
      if (out_valid && out_ready) begin
        if (expq.size() == 0) chk(1'b0, "R8", "extra byte", int'(out_data), 0);
        else begin
          logic [7:0] e;
          e = expq.pop_front();
          chk(out_data == e, "R5/R8", "byte value", int'(out_data), int'(e));
        end
        rcv++;
      end
      if (!oe_n) oe_low++;
      if (pce && !ce_n) begin
        chk(sr_model == exp_addr, "R3", "address in chain", int'(sr_model), int'(exp_addr));
        chk(pulses - last_pulses == 16, "R2", "shift pulses per address", pulses - last_pulses, 16);
        chk(we_n == 1'b1, "R6", "write enable", int'(we_n), 1);
        last_pulses = pulses;
        exp_addr = exp_addr + 16'd1;
        reads++;
      end
      if (poe && !oe_n) chk(!pce, "R4", "CE low before OE", int'(pce), 0);
      if (!pce && ce_n) begin
        chk(poe && oe_n, "R4", "OE high before CE", int'(poe), 1);
        chk(oe_low == ACC, "R5", "OE low cycles", oe_low, ACC);
        oe_low = 0;
      end
    end
    pv = out_valid; pr = out_ready; pd = out_data; pce = ce_n; poe = oe_n;
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run_dump(input int len, input int mode, input bit poke);
    ready_mode = mode;
    for (int a = 0; a < len; a++) expq.push_back(memf(16'(a)));
    exp_addr = '0;
    rcv = 0;
    @(negedge clk);
    start = 1'b1;
    dump_len = 17'(len);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (100) @(negedge clk);
      chk(busy == 1'b1, "R11", "busy mid dump", int'(busy), 1);
      start = 1'b1;
      dump_len = 17'd2;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(rcv == len, "R8", "byte count", rcv, len);
    chk(expq.size() == 0, "R8", "bytes missing", expq.size(), 0);
    chk(busy == 1'b0, "R9", "busy after done", int'(busy), 0);
    repeat (5) @(negedge clk);
    chk(done && !out_valid && ce_n, "R9", "done held idle", int'(done), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ce_n && oe_n && we_n && !sr_clk, "R1", "strobes in reset", int'({ce_n, oe_n, we_n, sr_clk}), 4'b1110);
    chk(!out_valid && !busy && !done, "R1", "flags in reset", int'({out_valid, busy, done}), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ce_n && oe_n && we_n && !done && !out_valid, "R1", "after reset", int'({ce_n, oe_n, done}), 3'b110);

    run_dump(3, 0, 1'b0);
    run_dump(5, 2, 1'b0);
    begin
      int r0;
      r0 = reads;
      @(negedge clk);
      start = 1'b1;
      dump_len = '0;
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b1, "R10", "done after zero length", int'(done), 1);
      repeat (20) @(negedge clk);
      chk(reads == r0, "R10", "no read for zero length", reads - r0, 0);
    end
    run_dump(260, 1, 1'b1);
    chk(exp_addr == 16'd260, "R3", "addresses read past carry", int'(exp_addr), 260);
    run_dump(1, 0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule